// File: doc/BRIEF.md
# DMA Channel Reload-Mode Address Sequencer

This block generates the source and destination addresses for one DMA channel. It keeps the total transfer count. Software loads five registers through a simple write port: source address, destination address, total count, reload count and control. The channel then serves transfer requests one at a time. On every accepted request it shows the current source address, destination address and transfer size code. At the edge that closes the cycle, it moves both addresses by the programmed step and decrements the total count.

Reload mode exists for code that sweeps the same input window again and again while it fills a growing output area. A write to the source register also loads a hidden copy of the source base. A small working counter counts down inside each period. When it runs out, the next transfer starts again at the base. The destination and the total count keep running. When the total count reaches zero the channel reports completion. It then refuses requests until software rewrites the count.

Top module: `dma_reload_seq`

## Requirements
- R1: After synchronous reset, both addresses and the total count read as zero and done is low. A request is not acknowledged.
- R2: Writing select 0 (source) loads the source address and also loads the shadow base. Select 1 writes the destination address, select 2 the total count, select 3 the reload register and select 4 the control register.
- R3: ack is high exactly when req is high, wr_en is low, done is low and the total count is non-zero. While ack is high, src_addr and dst_addr show the current address registers.
- R4: The source step mode sits in control bits 13:12 and the destination step mode in bits 15:14. Code 01 adds the step after each transfer, 10 subtracts it, and 00 or 11 leave the address unchanged.
- R5: The size code is {control bit 20, control bits 4:3}. Codes 0 to 4 give a step of 1, 2, 4, 8 or 16 bytes. Codes 5 to 7 give a step of 1. size_code shows the code.
- R6: Control bits 27:25 equal to 111 select reload mode. In that mode, an accepted transfer whose working counter is 1 or 0 reloads the source from the shadow base and refills the working counter from the interval. Any other accepted transfer decrements the working counter.
- R7: A source reload does not disturb the destination address, which keeps stepping in its own mode.
- R8: Each accepted transfer decrements the total count. The transfer that takes it from 1 to 0 sets done from the next cycle on. While done is high, requests get no ack and the addresses hold.
- R9: A write to the total count clears done and re-enables the channel when the new count is non-zero.
- R10: Outside reload mode the source address steps on every transfer and never rewinds.
- R11: The reload register keeps the interval in bits 23:16 and the initial working count in bits 7:0. The first period can therefore differ in length from the later ones.
- R12: A cycle with wr_en high accepts no transfer, even with req high. The write still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select (0 src, 1 dst, 2 count, 3 reload, 4 control) |
| wr_data | input | 32 | Write data |
| req | input | 1 | Transfer request |
| ack | output | 1 | Transfer accepted in this cycle |
| src_addr | output | ADDR_W | Current source address |
| dst_addr | output | ADDR_W | Current destination address |
| size_code | output | 3 | Current transfer size code |
| done | output | 1 | Total count exhausted |

## Verification
ack, src_addr, dst_addr and size_code are combinational from req and the registers. The bench therefore drives req on a falling edge and samples these outputs one time unit later, in the same cycle. Address and counter updates, including a source reload, appear after the next rising edge, so each following transfer check sees them. done is registered and is sampled on the falling edge after the final accepted transfer. A write counts from the rising edge that captures it, so its effect is checked one cycle later.

// File: rtl/dma_reload_pkg.sv
package dma_reload_pkg;

   localparam int DATA_W = 32;

   // register selects
   localparam logic [2:0] SEL_SRC  = 3'd0;
   localparam logic [2:0] SEL_DST  = 3'd1;
   localparam logic [2:0] SEL_CNT  = 3'd2;
   localparam logic [2:0] SEL_RLD  = 3'd3;
   localparam logic [2:0] SEL_CTRL = 3'd4;

   typedef enum logic [1:0] {
      STEP_HOLD = 2'b00,
      STEP_UP   = 2'b01,
      STEP_DOWN = 2'b10,
      STEP_RSVD = 2'b11
   } step_mode_e;

   typedef struct packed {
      logic [2:0] repeat_sel;
      step_mode_e dst_mode;
      step_mode_e src_mode;
      logic [2:0] size;
   } chan_ctrl_t;

   localparam logic [2:0] REPEAT_RELOAD_SRC = 3'b111;

   function automatic chan_ctrl_t decode_ctrl(input logic [DATA_W-1:0] d);
      chan_ctrl_t c;
      c.repeat_sel = d[27:25];
      c.dst_mode   = step_mode_e'(d[15:14]);
      c.src_mode   = step_mode_e'(d[13:12]);
      c.size       = {d[20], d[4:3]};
      return c;
   endfunction

   // byte step for a size code; reserved codes step by one
   function automatic logic [4:0] size_bytes(input logic [2:0] code);
      logic [4:0] b;
      if (code <= 3'd4) b = 5'd1 << code;
      else              b = 5'd1;
      return b;
   endfunction

endpackage

// File: rtl/dma_addr_step.sv
module dma_addr_step
   import dma_reload_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] cur,
   input  step_mode_e        mode,
   input  logic [4:0]        step,
   output logic [ADDR_W-1:0] nxt
);

   logic [ADDR_W-1:0] step_ext;
   assign step_ext = ADDR_W'(step);

   always_comb begin
      unique case (mode)
         STEP_UP:   nxt = cur + step_ext;
         STEP_DOWN: nxt = cur - step_ext;
         default:   nxt = cur;
      endcase
   end

endmodule

// File: rtl/dma_reload_ctr.sv
module dma_reload_ctr #(
   parameter int RLD_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [RLD_W-1:0] load_interval,
   input  logic [RLD_W-1:0] load_work,
   input  logic             advance,
   output logic             hit,
   output logic [RLD_W-1:0] work
);

   logic [RLD_W-1:0] interval_q;

   assign hit = (work <= RLD_W'(1));

   always_ff @(posedge clk) begin
      if (rst) begin
         interval_q <= '0;
         work       <= '0;
      end else if (load) begin
         interval_q <= load_interval;
         work       <= load_work;
      end else if (advance) begin
         if (hit) work <= interval_q;
         else     work <= work - RLD_W'(1);
      end
   end

endmodule

// File: rtl/dma_reload_seq.sv
module dma_reload_seq
   import dma_reload_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 24
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [2:0]        wr_sel,
   input  logic [31:0]       wr_data,
   input  logic              req,
   output logic              ack,
   output logic [ADDR_W-1:0] src_addr,
   output logic [ADDR_W-1:0] dst_addr,
   output logic [2:0]        size_code,
   output logic              done
);

   localparam int RLD_W  = 8;
   localparam int N_ADDR = 2;   // 0 = source, 1 = destination

   if (ADDR_W < 8 || ADDR_W > DATA_W) begin : g_bad_addr_w
      $error("ADDR_W must lie in 8..32");
   end
   if (CNT_W < 1 || CNT_W > DATA_W) begin : g_bad_cnt_w
      $error("CNT_W must lie in 1..32");
   end

   logic              unused_wr;
   assign unused_wr = ^wr_data;

   chan_ctrl_t        ctrl_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [ADDR_W-1:0] shadow_q;
   logic              done_q;
   logic              reload_mode;
   logic              rld_hit;
   logic [RLD_W-1:0]  rld_work;
   logic [4:0]        step_b;

   logic [ADDR_W-1:0] addr_q   [N_ADDR];
   logic [ADDR_W-1:0] addr_nxt [N_ADDR];
   step_mode_e        addr_mode[N_ADDR];
   logic [2:0]        addr_sel [N_ADDR];

   assign reload_mode = (ctrl_q.repeat_sel == REPEAT_RELOAD_SRC);
   assign step_b      = size_bytes(ctrl_q.size);
   assign ack         = req && !wr_en && !done_q && (cnt_q != '0);

   assign addr_mode[0] = ctrl_q.src_mode;
   assign addr_mode[1] = ctrl_q.dst_mode;
   assign addr_sel[0]  = SEL_SRC;
   assign addr_sel[1]  = SEL_DST;

   for (genvar ch = 0; ch < N_ADDR; ch++) begin : g_addr
      dma_addr_step #(.ADDR_W(ADDR_W)) u_step (
         .cur  (addr_q[ch]),
         .mode (addr_mode[ch]),
         .step (step_b),
         .nxt  (addr_nxt[ch])
      );

      if (ch == 0) begin : g_src
         always_ff @(posedge clk) begin
            if (rst) begin
               addr_q[ch] <= '0;
               shadow_q   <= '0;
            end else if (wr_en && wr_sel == addr_sel[ch]) begin
               addr_q[ch] <= wr_data[ADDR_W-1:0];
               shadow_q   <= wr_data[ADDR_W-1:0];
            end else if (ack) begin
               if (reload_mode && rld_hit) addr_q[ch] <= shadow_q;
               else                        addr_q[ch] <= addr_nxt[ch];
            end
         end
      end else begin : g_dst
         always_ff @(posedge clk) begin
            if (rst)                                 addr_q[ch] <= '0;
            else if (wr_en && wr_sel == addr_sel[ch]) addr_q[ch] <= wr_data[ADDR_W-1:0];
            else if (ack)                            addr_q[ch] <= addr_nxt[ch];
         end
      end
   end

   dma_reload_ctr #(.RLD_W(RLD_W)) u_rld (
      .clk           (clk),
      .rst           (rst),
      .load          (wr_en && wr_sel == SEL_RLD),
      .load_interval (wr_data[23:16]),
      .load_work     (wr_data[7:0]),
      .advance       (ack && reload_mode),
      .hit           (rld_hit),
      .work          (rld_work)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         ctrl_q <= '0;
      end else if (wr_en && wr_sel == SEL_CTRL) begin
         ctrl_q <= decode_ctrl(wr_data);
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else if (wr_en && wr_sel == SEL_CNT) begin
         cnt_q  <= wr_data[CNT_W-1:0];
         done_q <= 1'b0;
      end else if (ack) begin
         cnt_q <= cnt_q - CNT_W'(1);
         if (cnt_q == CNT_W'(1)) done_q <= 1'b1;
      end
   end

   assign src_addr  = addr_q[0];
   assign dst_addr  = addr_q[1];
   assign size_code = ctrl_q.size;
   assign done      = done_q;

endmodule

// File: rtl/dma_reload_seq_chk.sv
module dma_reload_seq_chk
   import dma_reload_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst,
   input logic              req,
   input logic              ack,
   input logic              done,
   input logic              wr_en,
   input logic [2:0]        wr_sel,
   input logic [ADDR_W-1:0] src_addr,
   input logic [ADDR_W-1:0] dst_addr,
   input logic [ADDR_W-1:0] shadow,
   input logic              reload_mode,
   input logic              rld_hit,
   input step_mode_e        dst_mode
);

   AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
      ack |-> (req && !done)) else $error("ack without request"); // R3

   AST_WRITE_BLOCKS_ACK: assert property (@(posedge clk) disable iff (rst)
      wr_en |-> !ack) else $error("ack during write"); // R12

   AST_DONE_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> !done) else $error("done set out of reset"); // R1

   AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
      (done && !(wr_en && wr_sel == SEL_CNT)) |=> done) else $error("done dropped"); // R8

   AST_IDLE_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!ack && !wr_en) |=> ($stable(src_addr) && $stable(dst_addr)))
      else $error("address moved while idle"); // R8

   AST_SRC_RELOAD: assert property (@(posedge clk) disable iff (rst)
      (ack && reload_mode && rld_hit) |=> (src_addr == $past(shadow)))
      else $error("source not rewound"); // R6

   AST_DST_HOLD_MODE: assert property (@(posedge clk) disable iff (rst)
      (ack && (dst_mode == STEP_HOLD || dst_mode == STEP_RSVD)) |=> $stable(dst_addr))
      else $error("fixed destination moved"); // R4

endmodule

bind dma_reload_seq dma_reload_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .req         (req),
   .ack         (ack),
   .done        (done),
   .wr_en       (wr_en),
   .wr_sel      (wr_sel),
   .src_addr    (src_addr),
   .dst_addr    (dst_addr),
   .shadow      (shadow_q),
   .reload_mode (reload_mode),
   .rld_hit     (rld_hit),
   .dst_mode    (ctrl_q.dst_mode)
);

// File: tb/dma_reload_seq_tb_top.sv
module dma_reload_seq_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W     = 32;
   localparam int N_VEC      = 12;

   // reload example: expected source / destination offsets per transfer
   localparam logic [31:0] VEC_SRC [N_VEC] = '{
      32'h0, 32'h4, 32'h8, 32'hC, 32'h0, 32'h4, 32'h8, 32'hC,
      32'h0, 32'h4, 32'h8, 32'hC};
   localparam logic [31:0] VEC_DST [N_VEC] = '{
      32'h00, 32'h04, 32'h08, 32'h0C, 32'h10, 32'h14, 32'h18, 32'h1C,
      32'h20, 32'h24, 32'h28, 32'h2C};

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              wr_en = 1'b0;
   logic [2:0]        wr_sel = '0;
   logic [31:0]       wr_data = '0;
   logic              req = 1'b0;
   logic              ack;
   logic [ADDR_W-1:0] src_addr;
   logic [ADDR_W-1:0] dst_addr;
   logic [2:0]        size_code;
   logic              done;

   int n_chk  = 0;
   int n_fail = 0;
   bit ended  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dma_reload_seq #(.ADDR_W(ADDR_W), .CNT_W(24)) dut_i (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .req(req), .ack(ack), .src_addr(src_addr), .dst_addr(dst_addr),
      .size_code(size_code), .done(done)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] sel, input logic [31:0] data);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = data;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // one request cycle; outputs are combinational, sampled mid-cycle
   task automatic xfer(input string tag, input logic exp_ack,
                       input logic [31:0] exp_src, input logic [31:0] exp_dst);
      @(negedge clk);
      req = 1'b1;
      #1;
      chk({tag, " ack"}, 32'(ack), 32'(exp_ack));
      chk({tag, " src"}, src_addr, exp_src);
      chk({tag, " dst"}, dst_addr, exp_dst);
      @(posedge clk);
      #1 req = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      if (!ended) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;

      // R1: reset state
      #1;
      chk("R1 done", 32'(done), 32'd0);
      xfer("R1 no-count", 1'b0, 32'h0, 32'h0);

      // R2 R6 R7 R5: reload example, longword, both incrementing
      wr(3'd0, 32'h0000_1000);
      wr(3'd1, 32'h0000_2000);
      wr(3'd2, 32'd12);
      wr(3'd3, 32'h0004_0004);
      wr(3'd4, 32'h0E00_5010);
      @(negedge clk); #1;
      chk("R5 size code", 32'(size_code), 32'd2);
      for (int i = 0; i < N_VEC; i++) begin
         xfer($sformatf("R6 R7 vec%0d", i), 1'b1,
              32'h1000 + VEC_SRC[i], 32'h2000 + VEC_DST[i]);
      end
      @(negedge clk); #1;
      chk("R8 done set", 32'(done), 32'd1);
      // R8: further requests ignored, addresses held (source already rewound)
      xfer("R8 ignored", 1'b0, 32'h1000, 32'h2030);
      xfer("R8 ignored again", 1'b0, 32'h1000, 32'h2030);

      // R9 R10 R4: rewrite count, byte size, source down, destination fixed
      wr(3'd4, 32'h0000_2000);
      wr(3'd0, 32'h0000_3000);
      wr(3'd2, 32'd3);
      @(negedge clk); #1;
      chk("R9 done cleared", 32'(done), 32'd0);
      xfer("R10 dec0", 1'b1, 32'h3000, 32'h2030);
      xfer("R10 dec1", 1'b1, 32'h2FFF, 32'h2030);
      xfer("R4 dec2", 1'b1, 32'h2FFE, 32'h2030);
      @(negedge clk); #1;
      chk("R8 done3", 32'(done), 32'd1);

      // R5 R4: 16-byte size, source up, destination down
      wr(3'd4, 32'h0010_9000);
      wr(3'd0, 32'h0000_0100);
      wr(3'd1, 32'h0000_0800);
      wr(3'd2, 32'd2);
      xfer("R5 sz16 a", 1'b1, 32'h100, 32'h800);
      xfer("R5 sz16 b", 1'b1, 32'h110, 32'h7F0);

      // R5 R4: reserved size code steps 1, destination mode 11 fixed
      wr(3'd4, 32'h0010_D018);
      wr(3'd0, 32'h0000_0040);
      wr(3'd1, 32'h0000_0090);
      wr(3'd2, 32'd2);
      @(negedge clk); #1;
      chk("R5 rsvd code", 32'(size_code), 32'd7);
      xfer("R5 rsvd a", 1'b1, 32'h40, 32'h90);
      xfer("R4 rsvd b", 1'b1, 32'h41, 32'h90);

      // R11 R12: first period 2, then 4; halfword; write during request
      wr(3'd4, 32'h0E00_5008);
      wr(3'd0, 32'h0000_0500);
      wr(3'd1, 32'h0000_0600);
      wr(3'd3, 32'h0004_0002);
      wr(3'd2, 32'd7);
      xfer("R11 t0", 1'b1, 32'h500, 32'h600);
      xfer("R11 t1", 1'b1, 32'h502, 32'h602);
      xfer("R11 t2 reload", 1'b1, 32'h500, 32'h604);
      @(negedge clk);
      req = 1'b1; wr_en = 1'b1; wr_sel = 3'd1; wr_data = 32'h0000_0700;
      #1;
      chk("R12 ack blocked", 32'(ack), 32'd0);
      @(posedge clk);
      #1 req = 1'b0; wr_en = 1'b0;
      xfer("R12 t3", 1'b1, 32'h502, 32'h700);
      xfer("R11 t4", 1'b1, 32'h504, 32'h702);
      xfer("R11 t5", 1'b1, 32'h506, 32'h704);
      xfer("R11 t6 reload", 1'b1, 32'h500, 32'h706);
      @(negedge clk); #1;
      chk("R8 done7", 32'(done), 32'd1);

      ended = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule